// File: doc/BRIEF.md
# Programmable Clock Output Router

This block sits behind an on-chip PLL and drives two clock pins. It sees two clock levels, the reference and the PLL output, and oversamples both with a faster system clock `clk_i`. The primary output can carry the PLL clock after a post-divider, the raw reference, or the reference after the same post-divider. The post-divider divides by twice its 5-bit setting. The secondary output can carry the reference, half the reference, the primary source, or half the primary source.

All routing and divider settings are static inputs held by fuse-style configuration. There are two complete sets. A single multipurpose control pin takes one of three roles: output enable, power-down, or set select. In its low state, each role gates the outputs in its own way. Each disabled output either floats or drives a steady low, as the configuration chooses. The pin is synchronised into `clk_i` by two flops. Output gates open and close only while their source is low, so no pulse is ever shortened.

Top module: `clkout_ctrl`

## Requirements
- R1: While `rst_ni` is low, `clk0_o` and `clk1_o` are 0.
- R2: Primary source code (`sX_c0_sel_i`): 0 = PLL divided by 2P, 1 = reference, 2 = reference divided by 2P; code 3 behaves as 1.
- R3: Secondary source code (`sX_c1_sel_i`): 0 = reference, 1 = reference / 2, 2 = ungated primary source, 3 = ungated primary source / 2.
- R4: The post-divider output toggles once every P rising edges of its source, giving a period of 2P source periods; P = 0 acts as P = 1.
- R5: Role code (`pin_role_i`) 0 = output enable, 1 = power-down, 2 = set select, 3 = no function; with code 3 the pin level has no effect on either output.
- R6: In output-enable role, a low pin stops `clk0_o` while `clk1_o` keeps running.
- R7: In power-down role, a low pin stops both outputs and clears all divider counters; after release the dividers restart and run at the configured rate.
- R8: A disabled output drives `clkN_o` = 0 with `clkN_oe_o` = 0 when `float_off_i` = 1, and with `clkN_oe_o` = 1 when `float_off_i` = 0.
- R9: In set-select role, a high pin applies set 1 (`s1_*`) and a low pin applies set 2 (`s2_*`); the pin reads high by default.
- R10: An output gate changes state only while its source is low, so every high pulse on an output has the full source width.
- R11: A new post-divider setting is loaded only at the divider's terminal count, so no half-period shorter than the old or new setting appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock level |
| pll_i | input | 1 | PLL clock level |
| pin_role_i | input | 2 | Role of the multipurpose pin |
| pin_i | input | 1 | Multipurpose control pin (asynchronous) |
| float_off_i | input | 1 | 1: disabled outputs float; 0: disabled outputs drive low |
| s1_post_i | input | P_W | Set 1 post-divider setting P |
| s1_c0_sel_i | input | 2 | Set 1 primary source code |
| s1_c1_sel_i | input | 2 | Set 1 secondary source code |
| s2_post_i | input | P_W | Set 2 post-divider setting P |
| s2_c0_sel_i | input | 2 | Set 2 primary source code |
| s2_c1_sel_i | input | 2 | Set 2 secondary source code |
| clk0_o | output | 1 | Primary clock data |
| clk0_oe_o | output | 1 | Primary pad output enable |
| clk1_o | output | 1 | Secondary clock data |
| clk1_oe_o | output | 1 | Secondary pad output enable |

## Verification
Two things can land in the same cycle. The set-select pin can switch to a set with a different P while the post-divider is partway through a count. The reload at terminal count must then keep every half-period whole. The bench flips the pin while the PLL divider runs with P = 2 in one set and P = 4 in the other. It then measures every complete high and low run across the switch and requires each to be at least the shorter half-period. The gate's close request can likewise meet a source rising edge in the same cycle. The bench provokes this by toggling the enable pin at a rate unrelated to the reference, and requires every high pulse to stay at full width.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int POST_W = 5;

  typedef enum logic [1:0] {
    ROLE_OE   = 2'd0,
    ROLE_PD   = 2'd1,
    ROLE_FSEL = 2'd2,
    ROLE_NONE = 2'd3
  } pin_role_e;

  localparam logic [1:0] C0_PLL_DIV = 2'd0;
  localparam logic [1:0] C0_REF     = 2'd1;
  localparam logic [1:0] C0_REF_DIV = 2'd2;

  localparam logic [1:0] C1_REF      = 2'd0;
  localparam logic [1:0] C1_REF_HALF = 2'd1;
  localparam logic [1:0] C1_C0       = 2'd2;
  localparam logic [1:0] C1_C0_HALF  = 2'd3;
endpackage

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         q_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] ratio_eff;

  // zero setting would stall the output; treat as one
  assign ratio_eff = (ratio_i == '0) ? W'(1) : ratio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q <= W'(1)) begin
        q_o   <= ~q_o;
        cnt_q <= ratio_eff;  // new setting taken only here
      end else begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assert_toggle_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o != $past(q_o)) && $past(run_i) |-> $past(tick_i));

  assert_stop_when_down_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!q_o && cnt_q == '0));
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic want_i,
  input  logic float_i,
  output logic data_o,
  output logic oe_o
);
  logic en_q;

  // enable moves only while the source is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b0;
    else if (!src_i) en_q <= want_i;
  end

  assign data_o = src_i & en_q;
  assign oe_o   = en_q | ~float_i;

  assert_gate_moves_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> !$past(src_i));

  assert_no_close_when_wanted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    want_i && $past(want_i) |-> !$fell(en_q));
endmodule

// File: rtl/clkout_mode.sv
module clkout_mode
  import clkout_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] role_i,
  input  logic       pin_i,
  output logic       run_o,
  output logic       want0_o,
  output logic       want1_o,
  output logic       sel2_o
);
  logic [1:0] sync_q;
  logic       pin_s;
  logic       oe_off, pd_off;

  // pin idles high: reset the synchroniser to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], pin_i};
  end
  assign pin_s = sync_q[1];

  assign oe_off  = (role_i == ROLE_OE)   && !pin_s;
  assign pd_off  = (role_i == ROLE_PD)   && !pin_s;
  assign sel2_o  = (role_i == ROLE_FSEL) && !pin_s;
  assign run_o   = !pd_off;
  assign want0_o = !oe_off && !pd_off;
  assign want1_o = !pd_off;

  assert_one_role_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({oe_off, pd_off, sel2_o}));

  assert_set2_only_in_select_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel2_o |-> (run_o && want0_o));
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int P_W = clkout_pkg::POST_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_i,
  input  logic           pll_i,
  input  logic [1:0]     pin_role_i,
  input  logic           pin_i,
  input  logic           float_off_i,
  input  logic [P_W-1:0] s1_post_i,
  input  logic [1:0]     s1_c0_sel_i,
  input  logic [1:0]     s1_c1_sel_i,
  input  logic [P_W-1:0] s2_post_i,
  input  logic [1:0]     s2_c0_sel_i,
  input  logic [1:0]     s2_c1_sel_i,
  output logic           clk0_o,
  output logic           clk0_oe_o,
  output logic           clk1_o,
  output logic           clk1_oe_o
);
  localparam int NDIV    = 4;
  localparam int D_PLL   = 0;
  localparam int D_REF   = 1;
  localparam int D_REFH  = 2;
  localparam int D_C0H   = 3;

  logic           run, want0, want1, sel2;
  logic [P_W-1:0] post;
  logic [1:0]     c0_sel, c1_sel;
  logic           ref_q, pll_q, c0_q;
  logic           c0_src, c1_src;
  logic [NDIV-1:0] tick, dq;
  logic [P_W-1:0]  ratio [NDIV];

  clkout_mode u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .role_i  (pin_role_i),
    .pin_i   (pin_i),
    .run_o   (run),
    .want0_o (want0),
    .want1_o (want1),
    .sel2_o  (sel2)
  );

  assign post   = sel2 ? s2_post_i   : s1_post_i;
  assign c0_sel = sel2 ? s2_c0_sel_i : s1_c0_sel_i;
  assign c1_sel = sel2 ? s2_c1_sel_i : s1_c1_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      pll_q <= 1'b0;
      c0_q  <= 1'b0;
    end else begin
      ref_q <= ref_i;
      pll_q <= pll_i;
      c0_q  <= c0_src;
    end
  end

  always_comb begin
    tick[D_PLL]  = pll_i  & ~pll_q;
    tick[D_REF]  = ref_i  & ~ref_q;
    tick[D_REFH] = ref_i  & ~ref_q;
    tick[D_C0H]  = c0_src & ~c0_q;
    ratio[D_PLL]  = post;
    ratio[D_REF]  = post;
    ratio[D_REFH] = P_W'(1);
    ratio[D_C0H]  = P_W'(1);
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    clkout_div #(.W(P_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run),
      .tick_i  (tick[g]),
      .ratio_i (ratio[g]),
      .q_o     (dq[g])
    );
  end

  always_comb begin
    unique case (c0_sel)
      C0_PLL_DIV: c0_src = dq[D_PLL];
      C0_REF_DIV: c0_src = dq[D_REF];
      default:    c0_src = ref_i;
    endcase
  end

  always_comb begin
    unique case (c1_sel)
      C1_REF:      c1_src = ref_i;
      C1_REF_HALF: c1_src = dq[D_REFH];
      C1_C0:       c1_src = c0_src;
      default:     c1_src = dq[D_C0H];
    endcase
  end

  clkout_gate u_gate0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (c0_src),
    .want_i  (want0),
    .float_i (float_off_i),
    .data_o  (clk0_o),
    .oe_o    (clk0_oe_o)
  );

  clkout_gate u_gate1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (c1_src),
    .want_i  (want1),
    .float_i (float_off_i),
    .data_o  (clk1_o),
    .oe_o    (clk1_oe_o)
  );

  assert_pd_drains_outputs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && $past(!run) && !ref_i && !$past(ref_i) |-> (!clk0_o && !clk1_o));
endmodule

// File: tb/clkout_ctrl_tb.sv
module clkout_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HALF   = 3;
  localparam int PLL_HALF   = 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_i = 1'b0;
  logic       pll_i = 1'b0;
  logic [1:0] pin_role_i = 2'd3;
  logic       pin_i = 1'b1;
  logic       float_off_i = 1'b0;
  logic [4:0] s1_post_i = 5'd3;
  logic [1:0] s1_c0_sel_i = 2'd0;
  logic [1:0] s1_c1_sel_i = 2'd0;
  logic [4:0] s2_post_i = 5'd3;
  logic [1:0] s2_c0_sel_i = 2'd0;
  logic [1:0] s2_c1_sel_i = 2'd0;
  logic       clk0_o, clk0_oe_o, clk1_o, clk1_oe_o;

  int checks = 0;
  int errors = 0;

  clkout_ctrl u_dut (
    .clk_i, .rst_ni, .ref_i, .pll_i, .pin_role_i, .pin_i, .float_off_i,
    .s1_post_i, .s1_c0_sel_i, .s1_c1_sel_i,
    .s2_post_i, .s2_c0_sel_i, .s2_c1_sel_i,
    .clk0_o, .clk0_oe_o, .clk1_o, .clk1_oe_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial forever begin
    repeat (REF_HALF) @(negedge clk_i);
    ref_i = ~ref_i;
  end

  initial forever begin
    repeat (PLL_HALF) @(negedge clk_i);
    pll_i = ~pll_i;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    return (which == 0) ? clk0_o : clk1_o;
  endfunction

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  // period and high time between two rising edges; 0 on timeout
  task automatic measure(input int which, output int per, output int hi);
    logic prev, cur;
    int t;
    per = 0; hi = 0;
    step(); prev = pick(which);
    t = 0;
    while (t < 1000) begin
      step(); cur = pick(which);
      if (!prev && cur) break;
      prev = cur; t++;
    end
    if (t >= 1000) return;
    prev = 1'b1;
    for (int n = 1; n < 1000; n++) begin
      step(); cur = pick(which);
      if (prev && !cur) hi = n;
      if (!prev && cur) begin per = n; return; end
      prev = cur;
    end
  endtask

  // rising-edge count and shortest complete high/low runs
  task automatic runs(input int which, input int cycles, input bit toggle_pin,
                      output int rises, output int minhi, output int minlo);
    logic prev, cur;
    int len;
    bit seen;
    rises = 0; minhi = 9999; minlo = 9999; len = 0; seen = 0;
    step(); prev = pick(which);
    for (int n = 0; n < cycles; n++) begin
      if (toggle_pin && (n % 17 == 16)) pin_i = ~pin_i;
      step(); cur = pick(which);
      len++;
      if (cur != prev) begin
        if (seen) begin
          if (prev && len < minhi) minhi = len;
          if (!prev && len < minlo) minlo = len;
        end
        if (cur) rises++;
        seen = 1; len = 0;
      end
      prev = cur;
    end
  endtask

  task automatic settle();
    repeat (120) step();
  endtask

  task automatic t_reset();
    repeat (4) step();
    chk("R1 clk0 in reset", int'(clk0_o), 0);
    chk("R1 clk1 in reset", int'(clk1_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_c0_sources();
    int per, hi;
    pin_role_i = 2'd3; pin_i = 1'b1;
    s1_post_i = 5'd3; s1_c0_sel_i = 2'd0; s1_c1_sel_i = 2'd0;
    settle(); measure(0, per, hi);
    chk("R2 pll/2P period", per, 12);
    chk("R4 pll/2P high", hi, 6);
    s1_c0_sel_i = 2'd1;
    settle(); measure(0, per, hi);
    chk("R2 ref period", per, 6);
    s1_c0_sel_i = 2'd2;
    settle(); measure(0, per, hi);
    chk("R2 ref/2P period", per, 36);
    s1_c0_sel_i = 2'd3;
    settle(); measure(0, per, hi);
    chk("R2 code3 as ref", per, 6);
    s1_c0_sel_i = 2'd0; s1_post_i = 5'd0;
    settle(); measure(0, per, hi);
    chk("R4 P=0 as P=1", per, 4);
    s1_post_i = 5'd3;
  endtask

  task automatic t_c1_sources();
    int per, hi;
    s1_c0_sel_i = 2'd0; s1_post_i = 5'd3;
    s1_c1_sel_i = 2'd0; settle(); measure(1, per, hi);
    chk("R3 c1 ref", per, 6);
    s1_c1_sel_i = 2'd1; settle(); measure(1, per, hi);
    chk("R3 c1 ref/2", per, 12);
    s1_c1_sel_i = 2'd2; settle(); measure(1, per, hi);
    chk("R3 c1 c0", per, 12);
    s1_c1_sel_i = 2'd3; settle(); measure(1, per, hi);
    chk("R3 c1 c0/2", per, 24);
  endtask

  task automatic t_role_none();
    int per, hi;
    pin_role_i = 2'd3; pin_i = 1'b0;
    s1_c0_sel_i = 2'd0; s1_c1_sel_i = 2'd0;
    s2_c0_sel_i = 2'd2; s2_post_i = 5'd7;
    settle(); measure(0, per, hi);
    chk("R5 role3 clk0 unaffected", per, 12);
    measure(1, per, hi);
    chk("R5 role3 clk1 unaffected", per, 6);
    pin_i = 1'b1;
  endtask

  task automatic t_oe();
    int per, hi, r, mh, ml;
    pin_role_i = 2'd0; s1_c0_sel_i = 2'd1; s1_c1_sel_i = 2'd1;
    float_off_i = 1'b1; pin_i = 1'b0;
    settle(); runs(0, 200, 0, r, mh, ml);
    chk("R6 clk0 stopped", r, 0);
    measure(1, per, hi);
    chk("R6 clk1 runs", per, 12);
    chk("R8 float oe0", int'(clk0_oe_o), 0);
    chk("R8 enabled oe1", int'(clk1_oe_o), 1);
    float_off_i = 1'b0;
    step();
    chk("R8 drive-low oe0", int'(clk0_oe_o), 1);
    chk("R8 drive-low data0", int'(clk0_o), 0);
    pin_i = 1'b1;
    settle(); measure(0, per, hi);
    chk("R6 clk0 back", per, 6);
  endtask

  task automatic t_gate_pulses();
    int r, mh, ml;
    pin_role_i = 2'd0; s1_c0_sel_i = 2'd1; pin_i = 1'b1;
    settle(); runs(0, 600, 1, r, mh, ml);
    chk("R10 pulses seen", int'(r > 5), 1);
    chk("R10 min high width", mh, 3);
    pin_i = 1'b1;
  endtask

  task automatic t_pd();
    int per, hi, r0, r1, mh, ml;
    pin_role_i = 2'd1; s1_c0_sel_i = 2'd0; s1_post_i = 5'd3; s1_c1_sel_i = 2'd0;
    float_off_i = 1'b1; pin_i = 1'b0;
    settle(); runs(0, 150, 0, r0, mh, ml);
    runs(1, 150, 0, r1, mh, ml);
    chk("R7 clk0 stopped", r0, 0);
    chk("R7 clk1 stopped", r1, 0);
    chk("R8 both float", int'({clk0_oe_o, clk1_oe_o}), 0);
    pin_i = 1'b1;
    settle(); measure(0, per, hi);
    chk("R7 restart rate", per, 12);
  endtask

  task automatic t_fsel();
    int per, hi;
    pin_role_i = 2'd2;
    s1_post_i = 5'd2; s1_c0_sel_i = 2'd0; s1_c1_sel_i = 2'd0;
    s2_post_i = 5'd5; s2_c0_sel_i = 2'd2; s2_c1_sel_i = 2'd1;
    pin_i = 1'b1; settle(); measure(0, per, hi);
    chk("R9 set1 clk0", per, 8);
    measure(1, per, hi);
    chk("R9 set1 clk1", per, 6);
    pin_i = 1'b0; settle(); measure(0, per, hi);
    chk("R9 set2 clk0", per, 60);
    measure(1, per, hi);
    chk("R9 set2 clk1", per, 12);
    pin_i = 1'b1;
  endtask

  task automatic t_reload();
    int per, hi, r, mh, ml;
    pin_role_i = 2'd2;
    s1_post_i = 5'd2; s1_c0_sel_i = 2'd0;
    s2_post_i = 5'd4; s2_c0_sel_i = 2'd0;
    pin_i = 1'b1; settle();
    runs(0, 800, 1, r, mh, ml);
    chk("R11 no short high", int'(mh >= 4), 1);
    chk("R11 no short low", int'(ml >= 4), 1);
    pin_i = 1'b0; settle(); measure(0, per, hi);
    chk("R11 new P period", per, 16);
    pin_i = 1'b1;
  endtask

  initial begin
    t_reset();
    t_c0_sources();
    t_c1_sources();
    t_role_none();
    t_oe();
    t_gate_pulses();
    t_pd();
    t_fsel();
    t_reload();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule